// File: doc/BRIEF.md
# Signed Binary to Packed Decimal Converter

The block turns a two's-complement signed integer into a packed decimal value made of decimal digit nibbles and a sign nibble in the least significant position. It also produces a four-bit condition field. The field marks whether the source is negative, positive or zero, and whether the source magnitude is too large for the available digits. With the default parameters the source is 128 bits wide and the result holds 31 digits plus the sign, which is also 128 bits.

A conversion starts with a single-cycle pulse on `start_i`, sampled together with the operand and the positive-sign select. The block forms the magnitude of the operand and compares it against the largest value the digits can represent. A value in range is converted one bit per cycle by a shift and add-3 engine. The block then pulses `done_o` with the result, `result_valid_o` and the flags. A value out of range skips the conversion. It finishes early, with only the flags updated, and `result_o` keeps its previous contents.

The sign flags always come from the source operand, not from the digits. A value such as 10^31, whose lower 31 digits are all zero, still reports as positive.

Top module: `bcd_conv`

## Requirements
- R1: After reset, `done_o`, `result_valid_o`, `result_o` and `flags_o` are all zero.
- R2: `flags_o` is {LT, GT, EQ, SO} from bit 3 down to bit 0. For a non-negative source, LT is 0, EQ is 1 exactly when the source is zero, and GT is 1 otherwise. The sign nibble `result_o[3:0]` is 0xC when `pref_sign_i`=0 and 0xF when `pref_sign_i`=1.
- R3: For a negative source, LT is 1, GT and EQ are 0, and the sign nibble is 0xD. The magnitude is the two's-complement negation of the source, and the carry crosses from the low half into the high half.
- R4: For an in-range source, nibble i (`result_o[4i+3:4i]`, i = 1..DIGITS) holds decimal digit i-1 of the magnitude, so the least significant digit sits in nibble 1.
- R5: SO is 1 exactly when the magnitude exceeds 10^DIGITS-1 (for 31 digits, 0x0000007E37BE2022_C0914B267FFFFFFF). It is set alongside the LT or GT flag. The most negative input gives LT|SO (0x9).
- R6: When SO is 1, `result_o` keeps its previous value and `result_valid_o` stays 0 during `done_o`.
- R7: The LT and GT flags follow the sign of the source even when the magnitude's low DIGITS digits are all zero (for example ±10^31 and 10^32).
- R8: Count the rising edge that samples `start_i` as edge 1. `done_o` rises on edge WIDTH+2 for an in-range source and on edge 2 for an overflowing source. It stays high for exactly one cycle.
- R9: While a conversion is in progress, `start_i` is ignored. The result and timing are those of the operand already accepted.
- R10: For an in-range source, `result_valid_o` is 1 during the `done_o` cycle, and `flags_o` is valid during `done_o` in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| operand_i | input | WIDTH (128) | Signed two's-complement source |
| pref_sign_i | input | 1 | Positive sign code select: 0 gives 0xC, 1 gives 0xF |
| done_o | output | 1 | One-cycle completion pulse |
| result_valid_o | output | 1 | Result updated this completion |
| result_o | output | 4*DIGITS+4 (128) | Packed decimal digits with the sign nibble at bits 3:0 |
| flags_o | output | 4 | {LT, GT, EQ, SO} |

## Verification
The bench builds the block with its default parameters: 128-bit width and 31 digits. This brings the exact overflow boundary within reach, at ±(10^31-1) against ±10^31, together with 10^32 and the most negative 128-bit value. It also reaches a negative source whose low half is zero, which exercises the carry into the high half. Expected digits come from repeated division by ten in the bench. Latency is measured in edges against WIDTH+2 and 2.

// File: rtl/bcdconv_pkg.sv
// Package: shared state type, flag bit positions and sign codes for the
// signed binary to packed decimal converter.
package bcdconv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_FIN  = 2'd2
    } conv_state_t;

    localparam int FLAG_LT = 3;
    localparam int FLAG_GT = 2;
    localparam int FLAG_EQ = 1;
    localparam int FLAG_SO = 0;

    localparam logic [3:0] SIGN_NEG   = 4'hD;
    localparam logic [3:0] SIGN_POS_C = 4'hC;
    localparam logic [3:0] SIGN_POS_F = 4'hF;
endpackage

// File: rtl/bcd_sign_mag.sv
// Module: bcd_sign_mag
// Forms the unsigned magnitude of a signed operand and classifies its sign.
// Negation is done per half: the low half is negated, and the high half is
// inverted and incremented only when the negated low half is zero.
// Assumes WIDTH is even. Purely combinational.
module bcd_sign_mag
    import bcdconv_pkg::*;
#(
    parameter int WIDTH = 128
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic             pref_sign_i,
    output logic [WIDTH-1:0] magnitude_o,
    output logic             is_neg_o,
    output logic             is_zero_o,
    output logic [3:0]       sign_code_o
);
    localparam int HALF = WIDTH / 2;

    logic [HALF-1:0] lo_neg;
    logic [HALF-1:0] hi_neg;

    // Two's-complement negation split across the halves.
    always_comb begin
        lo_neg = ~operand_i[HALF-1:0] + HALF'(1);
        hi_neg = ~operand_i[WIDTH-1:HALF] + HALF'(lo_neg == '0);
    end

    // Select magnitude and sign code from the sign bit.
    always_comb begin
        is_neg_o  = operand_i[WIDTH-1];
        is_zero_o = (operand_i == '0);
        if (is_neg_o) begin
            magnitude_o = {hi_neg, lo_neg};
            sign_code_o = SIGN_NEG;
        end else begin
            magnitude_o = operand_i;
            sign_code_o = pref_sign_i ? SIGN_POS_F : SIGN_POS_C;
        end
    end
endmodule

// File: rtl/bcd_range_chk.sv
// Module: bcd_range_chk
// Flags a magnitude larger than 10^DIGITS-1. The upper halves are compared
// first, and the lower halves decide only on a tie. Assumes 10^DIGITS fits
// in WIDTH bits. Purely combinational.
module bcd_range_chk #(
    parameter int WIDTH  = 128,
    parameter int DIGITS = 31
) (
    input  logic [WIDTH-1:0] magnitude_i,
    output logic             over_o
);
    localparam int HALF = WIDTH / 2;

    function automatic logic [WIDTH-1:0] calc_limit();
        logic [WIDTH-1:0] v;
        v = WIDTH'(1);
        for (int k = 0; k < DIGITS; k++) begin
            v = v * WIDTH'(10);
        end
        return v - WIDTH'(1);
    endfunction

    localparam logic [WIDTH-1:0] LIMIT = calc_limit();

    logic [HALF-1:0] mag_hi, mag_lo, lim_hi, lim_lo;

    // Two-level compare: upper halves, then lower halves on equality.
    always_comb begin
        mag_hi = magnitude_i[WIDTH-1:HALF];
        mag_lo = magnitude_i[HALF-1:0];
        lim_hi = LIMIT[WIDTH-1:HALF];
        lim_lo = LIMIT[HALF-1:0];
        if (mag_hi != lim_hi) over_o = (mag_hi > lim_hi);
        else                  over_o = (mag_lo > lim_lo);
    end
endmodule

// File: rtl/bcd_dabble.sv
// Module: bcd_dabble
// Sequential shift and add-3 engine. load_i captures a magnitude and clears
// the digits. Each step_i cycle adjusts every digit of 5 or more by 3, then
// shifts one magnitude bit (MSB first) into the digit register. After WIDTH
// steps the digits hold the decimal value, provided it fits in DIGITS digits.
module bcd_dabble #(
    parameter int WIDTH  = 128,
    parameter int DIGITS = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [WIDTH-1:0]      mag_i,
    input  logic                  step_i,
    output logic [4*DIGITS-1:0]   digits_o
);
    localparam int BCD_W = 4 * DIGITS;

    logic [WIDTH-1:0] bin_q;
    logic [BCD_W-1:0] bcd_q;
    logic [BCD_W-1:0] adj;

    // Per-digit add-3 correction ahead of the shift.
    for (genvar g = 0; g < DIGITS; g++) begin : g_adj
        always_comb begin
            if (bcd_q[4*g +: 4] >= 4'd5) adj[4*g +: 4] = bcd_q[4*g +: 4] + 4'd3;
            else                         adj[4*g +: 4] = bcd_q[4*g +: 4];
        end
    end

    // Load or advance the shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q <= '0;
            bcd_q <= '0;
        end else if (load_i) begin
            bin_q <= mag_i;
            bcd_q <= '0;
        end else if (step_i) begin
            bin_q <= {bin_q[WIDTH-2:0], 1'b0};
            bcd_q <= {adj[BCD_W-2:0], bin_q[WIDTH-1]};
        end
    end

    assign digits_o = bcd_q;
endmodule

// File: rtl/bcd_conv.sv
// Module: bcd_conv (top)
// Converts a signed WIDTH-bit operand to packed decimal with a sign nibble
// and returns {LT,GT,EQ,SO} flags taken from the source value. An operand
// out of range finishes early and leaves result_o unchanged. start_i is
// honoured only while idle. Assumes 10^DIGITS < 2^(WIDTH-1).
module bcd_conv
    import bcdconv_pkg::*;
#(
    parameter int WIDTH  = 128,
    parameter int DIGITS = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [WIDTH-1:0]        operand_i,
    input  logic                    pref_sign_i,
    output logic                    done_o,
    output logic                    result_valid_o,
    output logic [4*DIGITS+3:0]     result_o,
    output logic [3:0]              flags_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    conv_state_t        state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [3:0]         sign_q;
    logic [3:0]         flags_q;
    logic               ovf_q;

    logic [WIDTH-1:0]   magnitude;
    logic               is_neg, is_zero, over;
    logic [3:0]         sign_code;
    logic [3:0]         flags_new;
    logic               load, step;
    logic [4*DIGITS-1:0] digits;

    bcd_sign_mag #(.WIDTH(WIDTH)) sign_mag_i (
        .operand_i   (operand_i),
        .pref_sign_i (pref_sign_i),
        .magnitude_o (magnitude),
        .is_neg_o    (is_neg),
        .is_zero_o   (is_zero),
        .sign_code_o (sign_code)
    );

    bcd_range_chk #(.WIDTH(WIDTH), .DIGITS(DIGITS)) range_i (
        .magnitude_i (magnitude),
        .over_o      (over)
    );

    bcd_dabble #(.WIDTH(WIDTH), .DIGITS(DIGITS)) dabble_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .mag_i    (magnitude),
        .step_i   (step),
        .digits_o (digits)
    );

    // Flags derived from the source sign, zero test and range check.
    always_comb begin
        flags_new          = '0;
        flags_new[FLAG_LT] = is_neg;
        flags_new[FLAG_GT] = !is_neg && !is_zero;
        flags_new[FLAG_EQ] = is_zero;
        flags_new[FLAG_SO] = over;
    end

    // Engine controls: load on accepted start, step while converting.
    always_comb begin
        load = (state_q == ST_IDLE) && start_i;
        step = (state_q == ST_CONV);
    end

    // Sequencer: accept, iterate WIDTH times, then publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sign_q  <= '0;
            flags_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    sign_q  <= sign_code;
                    flags_q <= flags_new;
                    ovf_q   <= over;
                    cnt_q   <= CNT_W'(WIDTH);
                    state_q <= over ? ST_FIN : ST_CONV;
                end
                ST_CONV: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output registers: pulse done, update result only when in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o         <= 1'b0;
            result_valid_o <= 1'b0;
            result_o       <= '0;
            flags_o        <= '0;
        end else if (state_q == ST_FIN) begin
            done_o         <= 1'b1;
            flags_o        <= flags_q;
            result_valid_o <= !ovf_q;
            if (!ovf_q) result_o <= {digits, sign_q};
        end else begin
            done_o         <= 1'b0;
            result_valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/bcd_conv_checker.sv
// Module: bcd_conv_checker
// Port-level properties of bcd_conv, attached with a bind statement.
module bcd_conv_checker #(
    parameter int DIGITS = 31
) (
    input logic                clk,
    input logic                rst_n,
    input logic                done_o,
    input logic                result_valid_o,
    input logic [4*DIGITS+3:0] result_o,
    input logic [3:0]          flags_o
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_valid_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> done_o);

    assert_one_sign_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones(flags_o[3:1]) == 1);

    assert_no_overflow_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flags_o[0]) |-> (!result_valid_o && $stable(result_o)));

    assert_neg_sign_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_valid_o && flags_o[3]) |-> result_o[3:0] == 4'hD);

    assert_zero_digits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flags_o[1]) |-> (result_valid_o && result_o[4*DIGITS+3:4] == '0));

    assert_zero_not_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flags_o[1]) |-> !flags_o[0]);
endmodule

bind bcd_conv bcd_conv_checker #(.DIGITS(DIGITS)) checker_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .done_o         (done_o),
    .result_valid_o (result_valid_o),
    .result_o       (result_o),
    .flags_o        (flags_o)
);

// File: tb/bcd_conv_tb_top.sv
module bcd_conv_tb_top;
    localparam int WIDTH  = 128;
    localparam int DIGITS = 31;
    localparam logic [127:0] LIM = 128'h0000007E37BE2022_C0914B267FFFFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [WIDTH-1:0] operand_i = '0;
    logic pref_sign_i = 1'b0;
    logic done_o, result_valid_o;
    logic [4*DIGITS+3:0] result_o;
    logic [3:0] flags_o;

    int errors = 0;
    int checks = 0;
    int lat;
    logic [127:0] last_res = '0;

    always #5 clk = ~clk;

    bcd_conv #(.WIDTH(WIDTH), .DIGITS(DIGITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .pref_sign_i(pref_sign_i), .done_o(done_o), .result_valid_o(result_valid_o),
        .result_o(result_o), .flags_o(flags_o)
    );

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [127:0] exp_bcd(input logic [127:0] mag, input logic [3:0] s);
        logic [127:0] r;
        logic [127:0] m;
        r = '0;
        m = mag;
        r[3:0] = s;
        for (int i = 1; i <= DIGITS; i++) begin
            r[4*i +: 4] = 4'(m % 128'd10);
            m = m / 128'd10;
        end
        return r;
    endfunction

    // Issue one start and measure edges until done (start edge counts as 1).
    task automatic run_op(input logic [127:0] op, input logic ps);
        @(negedge clk);
        operand_i = op;
        pref_sign_i = ps;
        start_i = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end while (!done_o && lat < 1000);
    endtask

    // Run an in-range operand and check digits, sign, flags, valid, latency.
    task automatic t_inrange(input string tag, input logic [127:0] op, input logic ps,
                             input logic [127:0] mag, input logic [3:0] sgn,
                             input logic [3:0] fl);
        logic [127:0] exp;
        exp = exp_bcd(mag, sgn);
        run_op(op, ps);
        check({tag, " latency R8"}, 128'(lat), 128'(WIDTH + 2));
        check({tag, " digits R4"}, result_o, exp);
        check({tag, " flags R2/R3"}, 128'(flags_o), 128'(fl));
        check({tag, " valid R10"}, 128'(result_valid_o), 128'd1);
        @(negedge clk);
        check({tag, " done pulse R8"}, 128'(done_o), 128'd0);
        last_res = exp;
    endtask

    // Run an overflowing operand and check flags, hold and latency.
    task automatic t_over(input string tag, input logic [127:0] op, input logic [3:0] fl);
        run_op(op, 1'b0);
        check({tag, " latency R8"}, 128'(lat), 128'd2);
        check({tag, " flags R5 R7"}, 128'(flags_o), 128'(fl));
        check({tag, " valid low R6"}, 128'(result_valid_o), 128'd0);
        check({tag, " result held R6"}, result_o, last_res);
    endtask

    task automatic t_reset();
        check("reset done R1", 128'(done_o), 128'd0);
        check("reset valid R1", 128'(result_valid_o), 128'd0);
        check("reset result R1", result_o, 128'd0);
        check("reset flags R1", 128'(flags_o), 128'd0);
    endtask

    // A second start while busy must be ignored.
    task automatic t_busy();
        @(negedge clk);
        operand_i = 128'd4096;
        pref_sign_i = 1'b0;
        start_i = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start_i = (lat == 10);
            operand_i = (lat >= 10) ? 128'd0 - 128'd77 : 128'd4096;
        end while (!done_o && lat < 1000);
        start_i = 1'b0;
        check("busy latency R9", 128'(lat), 128'(WIDTH + 2));
        check("busy result R9", result_o, exp_bcd(128'd4096, 4'hC));
        check("busy flags R9", 128'(flags_o), 128'h4);
        last_res = exp_bcd(128'd4096, 4'hC);
        @(negedge clk);
        check("busy no second done R9", 128'(done_o), 128'd0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_inrange("zero ps0 R2", 128'd0, 1'b0, 128'd0, 4'hC, 4'h2);
        t_inrange("pos ps1 R2", 128'd1234567890123, 1'b1, 128'd1234567890123, 4'hF, 4'h4);
        t_inrange("neg R3", 128'd0 - 128'd987654321, 1'b0, 128'd987654321, 4'hD, 4'h8);
        t_inrange("neg one R3", {128{1'b1}}, 1'b1, 128'd1, 4'hD, 4'h8);
        t_inrange("neg carry R3", 128'd0 - (128'd1 << 64), 1'b0, 128'd1 << 64, 4'hD, 4'h8);
        t_inrange("max pos R5", LIM, 1'b0, LIM, 4'hC, 4'h4);
        t_inrange("max neg R5", 128'd0 - LIM, 1'b1, LIM, 4'hD, 4'h8);
        t_over("pos 10^31 R7", LIM + 128'd1, 4'h5);
        t_over("neg 10^31 R7", 128'd0 - (LIM + 128'd1), 4'h9);
        t_over("pos 10^32 R7", (LIM + 128'd1) * 128'd10, 4'h5);
        t_over("most neg R5", 128'd1 << 127, 4'h9);
        t_busy();
        t_over("hold after busy R6", {1'b0, {127{1'b1}}}, 4'h5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule